// File: doc/BRIEF.md
# Three-Operand Operand-Bypass Select Unit

This block picks where each source operand of the instruction in the execute stage comes from in a five-stage pipeline. The pipeline has two register files, one for integers and one for floating point. An operand can come from the register-file read, from the result held in the EX/MEM pipeline register, or from the result held in the MEM/WB register. Three operand paths (A, B, C) are resolved at once. Path C exists only for fused multiply-add style instructions that read a third source register.

Every instruction carries a float-enable bit down the pipe. A single destination number and write enable are shared by both register files, and that bit decides which file the result targets. A producer only bypasses to a consumer in the same register domain. Integer register 0 is hard-wired and is never bypassed. Float register 0 is an ordinary register.

The block is purely combinational. The B select also steers the store-data path, so a store sees the same bypassed value as the B operand.

Top module: `fwd_unit_r4`

## Requirements
- R1: Each select uses the code 2'b00 for the register-file value, 2'b10 for the EX/MEM result and 2'b01 for the MEM/WB result. The code 2'b11 is never produced.
- R2: A select is 2'b10 when the EX/MEM write enable is high, the EX/MEM destination equals that operand's source number, and the EX/MEM float-enable equals the execute-stage float-enable.
- R3: When EX/MEM and MEM/WB both match the same operand, the select is 2'b10 (the younger result wins).
- R4: A select is 2'b01 when EX/MEM does not match and MEM/WB matches under the same conditions as in R2, using the MEM/WB fields.
- R5: A producer whose write enable is low never causes a bypass.
- R6: In the integer domain (float-enable 0), destination 0 is never bypassed. In the float domain (float-enable 1), destination 0 is bypassed like any other register.
- R7: A producer whose float-enable differs from the execute-stage float-enable never causes a bypass, even when the register numbers are equal.
- R8: When the R4-type flag is low, select C is 2'b00 whatever rs3 and the producers hold.
- R9: Operands A, B and C follow identical matching and priority rules, each against its own source number.
- R10: The selects depend only on the current inputs and settle within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ex_rs1 | input | 5 | Source register number for operand A |
| id_ex_rs2 | input | 5 | Source register number for operand B and store data |
| id_ex_rs3 | input | 5 | Source register number for operand C |
| id_ex_fp_en | input | 1 | Float-enable of the instruction in execute |
| id_ex_is_r4 | input | 1 | Instruction in execute reads a third source |
| ex_mem_rd | input | 5 | Destination number in EX/MEM |
| ex_mem_wen | input | 1 | Register write enable in EX/MEM |
| ex_mem_fp_en | input | 1 | Float-enable in EX/MEM |
| mem_wb_rd | input | 5 | Destination number in MEM/WB |
| mem_wb_wen | input | 1 | Register write enable in MEM/WB |
| mem_wb_fp_en | input | 1 | Float-enable in MEM/WB |
| fwd_sel_a | output | 2 | Select for operand A |
| fwd_sel_b | output | 2 | Select for operand B and store data |
| fwd_sel_c | output | 2 | Select for operand C |

## Verification
All three selects are due in the same cycle as the inputs that produce them, because there is no register between inputs and outputs. The bench drives a new input set on the falling clock edge. It then waits a few nanoseconds, still in the low phase, and compares all three selects with its own model before the next rising edge, so no check depends on the order of events at a clock edge. Each scenario task covers a particular case: the priority collision, a disabled producer, register 0 in each domain, a domain mismatch and the R4 gate. A final deterministic sweep mixes these conditions across all three operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_num,
  input  logic             src_used,
  input  logic             cons_fp,
  input  logic [REG_W-1:0] prod_rd,
  input  logic             prod_wen,
  input  logic             prod_fp,
  output logic             hit
);
  // Integer register 0 is hard-wired; float register 0 is real storage.
  function automatic logic dest_is_live(input logic [REG_W-1:0] rd, input logic fp);
    return fp || (rd != '0);
  endfunction

  function automatic logic producer_hits(
    input logic [REG_W-1:0] rs, input logic used, input logic cfp,
    input logic [REG_W-1:0] rd, input logic wen, input logic pfp);
    return used && wen && (rd == rs) && (pfp == cfp) && dest_is_live(rd, pfp);
  endfunction

  assign hit = producer_hits(src_num, src_used, cons_fp, prod_rd, prod_wen, prod_fp);
endmodule

// File: rtl/fwd_sel_pick.sv
module fwd_sel_pick
  import fwd_pkg::*;
(
  input  logic     exm_hit,
  input  logic     wb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (exm_hit)     sel = FWD_EXM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_unit_r4.sv
module fwd_unit_r4
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_ex_rs1,
  input  logic [REG_W-1:0] id_ex_rs2,
  input  logic [REG_W-1:0] id_ex_rs3,
  input  logic             id_ex_fp_en,
  input  logic             id_ex_is_r4,
  input  logic [REG_W-1:0] ex_mem_rd,
  input  logic             ex_mem_wen,
  input  logic             ex_mem_fp_en,
  input  logic [REG_W-1:0] mem_wb_rd,
  input  logic             mem_wb_wen,
  input  logic             mem_wb_fp_en,
  output logic [SEL_W-1:0] fwd_sel_a,
  output logic [SEL_W-1:0] fwd_sel_b,
  output logic [SEL_W-1:0] fwd_sel_c
);
  localparam int NUM_SRC = 3;

  logic [REG_W-1:0] src_num [NUM_SRC];
  logic [NUM_SRC-1:0] src_used;
  // Named match events, observed by the bound checker.
  logic [NUM_SRC-1:0] ex_hit;
  logic [NUM_SRC-1:0] wb_hit;
  fwd_sel_e sel_vec [NUM_SRC];

  assign src_num[0] = id_ex_rs1;
  assign src_num[1] = id_ex_rs2;
  assign src_num[2] = id_ex_rs3;
  // The third path is live only for three-source instructions.
  assign src_used   = {id_ex_is_r4, 1'b1, 1'b1};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_src_match #(.REG_W(REG_W)) u_exm (
      .src_num (src_num[g]), .src_used(src_used[g]), .cons_fp(id_ex_fp_en),
      .prod_rd (ex_mem_rd),  .prod_wen(ex_mem_wen),  .prod_fp(ex_mem_fp_en),
      .hit     (ex_hit[g])
    );
    fwd_src_match #(.REG_W(REG_W)) u_wb (
      .src_num (src_num[g]), .src_used(src_used[g]), .cons_fp(id_ex_fp_en),
      .prod_rd (mem_wb_rd),  .prod_wen(mem_wb_wen),  .prod_fp(mem_wb_fp_en),
      .hit     (wb_hit[g])
    );
    fwd_sel_pick u_pick (
      .exm_hit(ex_hit[g]), .wb_hit(wb_hit[g]), .sel(sel_vec[g])
    );
  end

  assign fwd_sel_a = sel_vec[0];
  assign fwd_sel_b = sel_vec[1];
  assign fwd_sel_c = sel_vec[2];
endmodule

// File: rtl/fwd_unit_r4_chk.sv
module fwd_unit_r4_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] id_ex_rs1,
  input logic             id_ex_fp_en,
  input logic             id_ex_is_r4,
  input logic             ex_mem_wen,
  input logic             ex_mem_fp_en,
  input logic             mem_wb_wen,
  input logic             mem_wb_fp_en,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b,
  input logic [1:0]       fwd_sel_c,
  input logic [2:0]       ex_hit,
  input logic [2:0]       wb_hit
);
  logic [1:0] sel_arr [3];
  assign sel_arr[0] = fwd_sel_a;
  assign sel_arr[1] = fwd_sel_b;
  assign sel_arr[2] = fwd_sel_c;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      assert_legal_code_R1: assert (sel_arr[i] != 2'b11)
        else $error("illegal select code on path %0d", i);
      assert_exm_wins_R3: assert (!ex_hit[i] || sel_arr[i] == 2'b10)
        else $error("EX/MEM match not selected on path %0d", i);
      assert_wb_fallback_R4: assert (ex_hit[i] || !wb_hit[i] || sel_arr[i] == 2'b01)
        else $error("MEM/WB match not selected on path %0d", i);
      assert_rf_default_R9: assert (ex_hit[i] || wb_hit[i] || sel_arr[i] == 2'b00)
        else $error("bypass without match on path %0d", i);
      assert_wen_gate_R5: assert ((ex_mem_wen || sel_arr[i] != 2'b10) &&
                                  (mem_wb_wen || sel_arr[i] != 2'b01))
        else $error("bypass from disabled producer on path %0d", i);
      assert_domain_R7: assert ((ex_mem_fp_en == id_ex_fp_en || sel_arr[i] != 2'b10) &&
                                (mem_wb_fp_en == id_ex_fp_en || sel_arr[i] != 2'b01))
        else $error("cross-domain bypass on path %0d", i);
    end
    assert_int_zero_R6: assert (id_ex_fp_en || id_ex_rs1 != '0 || fwd_sel_a == 2'b00)
      else $error("integer register 0 bypassed");
    assert_r4_gate_R8: assert (id_ex_is_r4 || fwd_sel_c == 2'b00)
      else $error("operand C bypassed for non-R4 instruction");
  end
endmodule

bind fwd_unit_r4 fwd_unit_r4_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/fwd_unit_r4_tb_top.sv
module fwd_unit_r4_tb_top;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [REG_W-1:0] rs1, rs2, rs3, exm_rd, wb_rd;
  logic fp, r4, exm_wen, exm_fp, wb_wen, wb_fp;
  logic [1:0] sel_a, sel_b, sel_c;

  int n_checks = 0;
  int n_errors = 0;

  fwd_unit_r4 #(.REG_W(REG_W)) dut_i (
    .id_ex_rs1(rs1), .id_ex_rs2(rs2), .id_ex_rs3(rs3),
    .id_ex_fp_en(fp), .id_ex_is_r4(r4),
    .ex_mem_rd(exm_rd), .ex_mem_wen(exm_wen), .ex_mem_fp_en(exm_fp),
    .mem_wb_rd(wb_rd), .mem_wb_wen(wb_wen), .mem_wb_fp_en(wb_fp),
    .fwd_sel_a(sel_a), .fwd_sel_b(sel_b), .fwd_sel_c(sel_c)
  );

  // Independent reference: one producer qualifies for one source.
  function automatic bit qualifies(logic [REG_W-1:0] rs, bit used, bit cfp,
                                   logic [REG_W-1:0] rd, bit wen, bit pfp);
    if (!used || !wen) return 0;
    if (pfp != cfp) return 0;
    if (rd != rs) return 0;
    if (!pfp && rs == 0) return 0;
    return 1;
  endfunction

  function automatic logic [1:0] model(logic [REG_W-1:0] rs, bit used);
    bit e = qualifies(rs, used, fp, exm_rd, exm_wen, exm_fp);
    bit w = qualifies(rs, used, fp, wb_rd, wb_wen, wb_fp);
    return e ? 2'b10 : (w ? 2'b01 : 2'b00);
  endfunction

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [REG_W-1:0] a, b, c, bit f, bit q,
                       logic [REG_W-1:0] er, bit ew, bit ef,
                       logic [REG_W-1:0] wr, bit ww, bit wf);
    @(negedge clk);
    rs1 = a; rs2 = b; rs3 = c; fp = f; r4 = q;
    exm_rd = er; exm_wen = ew; exm_fp = ef;
    wb_rd = wr; wb_wen = ww; wb_fp = wf;
    #3; // settled within the same low phase (R10)
  endtask

  task automatic t_idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "idle A", sel_a, 2'b00);
    chk("R1", "idle B", sel_b, 2'b00);
    chk("R1", "idle C", sel_c, 2'b00);
  endtask

  task automatic t_exm_fwd();
    drive(5, 6, 7, 0, 0, 5, 1, 0, 9, 0, 0);
    chk("R2", "EX/MEM to A", sel_a, 2'b10);
    chk("R10", "B unaffected", sel_b, 2'b00);
    drive(5, 6, 7, 1, 1, 7, 1, 1, 9, 0, 1);
    chk("R2", "EX/MEM to C fp", sel_c, 2'b10);
  endtask

  task automatic t_priority();
    drive(3, 3, 3, 1, 1, 3, 1, 1, 3, 1, 1);
    chk("R3", "both match A", sel_a, 2'b10);
    chk("R3", "both match B", sel_b, 2'b10);
    chk("R3", "both match C", sel_c, 2'b10);
  endtask

  task automatic t_wb_fwd();
    drive(4, 8, 2, 0, 0, 11, 1, 0, 8, 1, 0);
    chk("R4", "MEM/WB to B", sel_b, 2'b01);
    chk("R4", "A stays RF", sel_a, 2'b00);
    drive(8, 8, 8, 0, 0, 8, 1, 1, 8, 1, 0);
    chk("R4", "WB when EX/MEM other domain", sel_a, 2'b01);
  endtask

  task automatic t_wen_off();
    drive(12, 12, 12, 0, 1, 12, 0, 0, 12, 0, 0);
    chk("R5", "no wen A", sel_a, 2'b00);
    chk("R5", "no wen C", sel_c, 2'b00);
    drive(12, 12, 12, 0, 1, 12, 0, 0, 12, 1, 0);
    chk("R5", "only WB enabled", sel_b, 2'b01);
  endtask

  task automatic t_reg_zero();
    drive(0, 0, 0, 0, 1, 0, 1, 0, 0, 1, 0);
    chk("R6", "int x0 A", sel_a, 2'b00);
    chk("R6", "int x0 C", sel_c, 2'b00);
    drive(0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 1);
    chk("R6", "float f0 A", sel_a, 2'b10);
    chk("R6", "float f0 C", sel_c, 2'b10);
    drive(0, 1, 1, 1, 0, 9, 0, 1, 0, 1, 1);
    chk("R6", "float f0 via WB", sel_a, 2'b01);
  endtask

  task automatic t_domain();
    drive(10, 10, 10, 1, 1, 10, 1, 0, 10, 1, 0);
    chk("R7", "int producers, fp consumer A", sel_a, 2'b00);
    chk("R7", "int producers, fp consumer C", sel_c, 2'b00);
    drive(10, 10, 10, 0, 0, 10, 1, 1, 10, 1, 1);
    chk("R7", "fp producers, int consumer B", sel_b, 2'b00);
  endtask

  task automatic t_r4_gate();
    drive(1, 2, 15, 1, 0, 15, 1, 1, 15, 1, 1);
    chk("R8", "non-R4 C via EX/MEM", sel_c, 2'b00);
    drive(1, 2, 15, 1, 0, 20, 1, 1, 15, 1, 1);
    chk("R8", "non-R4 C via WB", sel_c, 2'b00);
    drive(1, 2, 15, 1, 1, 20, 1, 1, 15, 1, 1);
    chk("R8", "R4 C via WB", sel_c, 2'b01);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 400; i++) begin
      bit f = i[0];
      bit q = i[1];
      drive(REG_W'(i % 4), REG_W'((i / 3) % 4), REG_W'((i / 5) % 4), f, q,
            REG_W'((i / 7) % 4), i[2], f ^ i[5],
            REG_W'((i / 11) % 4), i[3], f ^ i[6]);
      chk("R9", "sweep A", sel_a, model(rs1, 1));
      chk("R9", "sweep B", sel_b, model(rs2, 1));
      chk("R9", "sweep C", sel_c, model(rs3, r4));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rs1 = 0; rs2 = 0; rs3 = 0; fp = 0; r4 = 0;
    exm_rd = 0; exm_wen = 0; exm_fp = 0; wb_rd = 0; wb_wen = 0; wb_fp = 0;
    repeat (2) @(posedge clk);
    t_idle();
    t_exm_fwd();
    t_priority();
    t_wb_fwd();
    t_wen_off();
    t_reg_zero();
    t_domain();
    t_r4_gate();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule